// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block turns a logical reference from a small 16-bit processor core into the address that goes onto the bus. It holds four 16-bit segment bases: extra, code, stack and data. A memory request picks one of them from the kind of reference being made. The block shifts that base left by four bit positions and adds the 16-bit offset, which gives a 20-bit physical address in a 1 Mbyte space. For data and BP-based references, an explicit override can replace the implied segment.

Port requests do not use segments. The 16-bit port number comes either from the DX value or from an 8-bit immediate, and the immediate is zero-extended. The result is registered together with a valid strobe and a flag that marks port results. Decode of the instruction and the bus cycle itself happen outside this block.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset the code segment holds 0xFFFF and the extra, stack and data segments hold 0x0000. `addr_valid` is 0 until the first request.
- R2: A memory address equals (segment << 4) + offset, taken modulo 2^20, so any carry out of bit 19 is dropped.
- R3: A fetch (`ref_kind` = 0) always uses the code segment, and `ovr_valid` has no effect on it.
- R4: A stack push or pop (`ref_kind` = 1) always uses the stack segment, and `ovr_valid` has no effect on it.
- R5: A BP-based reference (`ref_kind` = 2) uses the stack segment. When `ovr_valid` is 1 it uses the segment named by `ovr_sel` instead.
- R6: A data reference (`ref_kind` = 3, 6 or 7) uses the data segment. When `ovr_valid` is 1 it uses the segment named by `ovr_sel` instead. The segment codes on `ovr_sel` and `seg_sel` are: 0 extra, 1 code, 2 stack, 3 data.
- R7: An immediate port request (`ref_kind` = 4) gives the address {12'h000, `port_imm`} and sets `addr_io`.
- R8: A DX port request (`ref_kind` = 5) gives the address {4'h0, `dx`} and sets `addr_io`. A memory request clears `addr_io`.
- R9: `addr_valid` is 1 exactly in the cycle after a cycle with `req` high. `addr_out` and `addr_io` hold their values while `req` is low.
- R10: A segment write (`seg_we`, `seg_sel`, `seg_wdata`) takes effect at the clock edge. A request in the same cycle as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment register write enable |
| seg_sel | input | 2 | Segment register to write |
| seg_wdata | input | 16 | Segment write data |
| req | input | 1 | Request strobe |
| ref_kind | input | 3 | Reference type |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| offset | input | 16 | Memory offset |
| dx | input | 16 | DX port value |
| port_imm | input | 8 | Immediate port number |
| addr_out | output | 20 | Registered physical or port address |
| addr_valid | output | 1 | Address valid, one cycle after `req` |
| addr_io | output | 1 | Result is a port address |

## Verification
Each reference kind is driven twice: once with the override absent and once with it present and pointing at a segment loaded with a distinct base. This separates the kinds where the override must be ignored from the kinds where it must be honoured. Some cases put 0xFFFF in a segment and add an offset that carries past bit 19, which shows whether the sum wraps or saturates. Port requests use a DX value and an immediate that differ in the upper byte, so a wrong source selection or a missing zero-extension is caught. A segment write made in the same cycle as a request shows whether the request reads the old value or the new one.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int SEG_W  = 16,
  parameter int SHIFT  = 4,
  parameter int PORT_W = 8,
  localparam int PA_W  = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_we,
  input  logic [1:0]        seg_sel,
  input  logic [SEG_W-1:0]  seg_wdata,
  input  logic              req,
  input  logic [2:0]        ref_kind,
  input  logic              ovr_valid,
  input  logic [1:0]        ovr_sel,
  input  logic [SEG_W-1:0]  offset,
  input  logic [SEG_W-1:0]  dx,
  input  logic [PORT_W-1:0] port_imm,
  output logic [PA_W-1:0]   addr_out,
  output logic              addr_valid,
  output logic              addr_io
);
  localparam logic [2:0] K_FETCH = 3'd0, K_STACK = 3'd1, K_BP = 3'd2,
                         K_IO_IMM = 3'd4, K_IO_DX = 3'd5;
  localparam logic [1:0] S_CS = 2'd1, S_SS = 2'd2, S_DS = 2'd3;

  logic [SEG_W-1:0] seg_q [4];
  logic [1:0] dflt_sel, eff_sel;

  wire is_io   = (ref_kind == K_IO_IMM) || (ref_kind == K_IO_DX);
  wire can_ovr = !is_io && (ref_kind != K_FETCH) && (ref_kind != K_STACK);

  always_comb begin
    case (ref_kind)
      K_FETCH:      dflt_sel = S_CS;
      K_STACK, K_BP: dflt_sel = S_SS;
      default:      dflt_sel = S_DS;
    endcase
  end

  assign eff_sel = (ovr_valid && can_ovr) ? ovr_sel : dflt_sel;

  wire [PA_W-1:0]  mem_pa = {seg_q[eff_sel], {SHIFT{1'b0}}} + PA_W'(offset);
  wire [SEG_W-1:0] port_a = (ref_kind == K_IO_DX) ? dx : SEG_W'(port_imm);
  wire [PA_W-1:0]  next_a = is_io ? PA_W'(port_a) : mem_pa;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
      addr_io    <= 1'b0;
      for (int i = 0; i < 4; i++)
        seg_q[i] <= (i == int'(S_CS)) ? '1 : '0;
    end else begin
      addr_valid <= req;
      if (req) begin
        addr_out <= next_a;
        addr_io  <= is_io;
      end
      if (seg_we) seg_q[seg_sel] <= seg_wdata;
    end
  end
endmodule

module seg_addr_unit_chk #(
  parameter int SEG_W  = 16,
  parameter int SHIFT  = 4,
  parameter int PORT_W = 8,
  localparam int PA_W  = SEG_W + SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [2:0]        ref_kind,
  input logic [SEG_W-1:0]  dx,
  input logic [PORT_W-1:0] port_imm,
  input logic [PA_W-1:0]   addr_out,
  input logic              addr_valid,
  input logic              addr_io
);
  p_valid_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !addr_valid);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(addr_out) && $stable(addr_io)));
  p_io_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_io) |-> (addr_out[PA_W-1:SEG_W] == '0));
  p_io_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ref_kind == 3'd4) |=> (addr_io && addr_out == PA_W'($past(port_imm))));
  p_io_dx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ref_kind == 3'd5) |=> (addr_io && addr_out == PA_W'($past(dx))));
  p_mem_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ref_kind != 3'd4 && ref_kind != 3'd5) |=> !addr_io);
endmodule

bind seg_addr_unit seg_addr_unit_chk i_chk (.*);

// File: tb/test_seg_addr_unit.sv
`timescale 1ns/1ps
module test_seg_addr_unit;
  logic clk = 0, rst_n = 0;
  logic seg_we = 0; logic [1:0] seg_sel = 0; logic [15:0] seg_wdata = 0;
  logic req = 0; logic [2:0] ref_kind = 0; logic ovr_valid = 0; logic [1:0] ovr_sel = 0;
  logic [15:0] offset = 0, dx = 0; logic [7:0] port_imm = 0;
  logic [19:0] addr_out; logic addr_valid, addr_io;
  int checks = 0, errors = 0; bit done = 0;

  always #2.5 clk = ~clk;

  seg_addr_unit i_seg_addr_unit (.*);

  task automatic chk(string tag, logic [19:0] got, logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr_seg(logic [1:0] s, logic [15:0] v);
    @(negedge clk); seg_we = 1; seg_sel = s; seg_wdata = v;
    @(posedge clk); #1 seg_we = 0;
  endtask

  task automatic issue(logic [2:0] k, logic ov, logic [1:0] os, logic [15:0] off);
    @(negedge clk); req = 1; ref_kind = k; ovr_valid = ov; ovr_sel = os; offset = off;
    @(posedge clk); #1 req = 0; ovr_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 valid after reset", 20'(addr_valid), 20'h0);
    issue(3'd0, 0, 0, 16'h0000); chk("R1 CS reset", addr_out, 20'hFFFF0);
    issue(3'd3, 0, 0, 16'h1234); chk("R1 DS reset", addr_out, 20'h01234);
    chk("R9 valid after req", 20'(addr_valid), 20'h1);
  endtask

  task automatic t_wrap;
    issue(3'd0, 0, 0, 16'h0020); chk("R2 wrap", addr_out, 20'h00010);
    wr_seg(2'd3, 16'h1234);
    issue(3'd3, 0, 0, 16'h5678); chk("R2 sum", addr_out, 20'h179B8);
  endtask

  task automatic t_fetch_stack;
    wr_seg(2'd0, 16'h2000); wr_seg(2'd1, 16'h1000); wr_seg(2'd2, 16'h3000);
    issue(3'd0, 1, 2'd0, 16'h0004); chk("R3 fetch ignores override", addr_out, 20'h10004);
    issue(3'd1, 1, 2'd0, 16'h0008); chk("R4 stack ignores override", addr_out, 20'h30008);
  endtask

  task automatic t_bp_data;
    issue(3'd2, 0, 2'd0, 16'h0010); chk("R5 BP default SS", addr_out, 20'h30010);
    issue(3'd2, 1, 2'd0, 16'h0010); chk("R5 BP override ES", addr_out, 20'h20010);
    issue(3'd3, 0, 2'd0, 16'h0020); chk("R6 data default DS", addr_out, 20'h12360);
    issue(3'd3, 1, 2'd1, 16'h0020); chk("R6 data override CS", addr_out, 20'h10020);
    issue(3'd6, 1, 2'd2, 16'h0001); chk("R6 kind6 override SS", addr_out, 20'h30001);
  endtask

  task automatic t_io;
    @(negedge clk); dx = 16'hFFFF; port_imm = 8'hAB;
    issue(3'd4, 0, 0, 16'h5555);
    chk("R7 imm port", addr_out, 20'h000AB); chk("R7 io flag", 20'(addr_io), 20'h1);
    @(negedge clk); dx = 16'hBEEF;
    issue(3'd5, 0, 0, 16'h5555);
    chk("R8 dx port", addr_out, 20'h0BEEF); chk("R8 io flag", 20'(addr_io), 20'h1);
    issue(3'd3, 0, 0, 16'h0000); chk("R8 mem clears io", 20'(addr_io), 20'h0);
  endtask

  task automatic t_hold;
    @(posedge clk); #1;
    chk("R9 valid drops", 20'(addr_valid), 20'h0);
    chk("R9 addr holds", addr_out, 20'h12340);
  endtask

  task automatic t_same_cycle;
    @(negedge clk); seg_we = 1; seg_sel = 2'd3; seg_wdata = 16'h4000;
    req = 1; ref_kind = 3'd3; ovr_valid = 0; offset = 16'h0005;
    @(posedge clk); #1 seg_we = 0; req = 0;
    chk("R10 old value used", addr_out, 20'h12345);
    issue(3'd3, 0, 0, 16'h0005); chk("R10 new value next", addr_out, 20'h40005);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    t_reset(); t_wrap(); t_fetch_stack(); t_bp_data(); t_io(); t_hold(); t_same_cycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule